// File: doc/BRIEF.md
# Byte-Wide Clock Register Window with Shadow Snapshot

This block sits on a synchronous, byte-wide memory bus with chip select, write enable and output enable. The eight highest addresses of the byte space (1FF8h to 1FFFh with the default 13-bit address) form a clock register window. Every other address is handed to ordinary memory through a select output, and the read data for those addresses comes from the memory's data input.

The window does not hold the running time. It holds shadow copies of seven time bytes. On every one-second tick from an external calendar counter, all seven bytes are reloaded from that counter in one cycle. A read-halt bit in the control byte freezes these copies so that software can read a consistent time while the counter keeps running. A write-halt bit also freezes them, and it unlocks the time fields for bus writes. Clearing the write-halt bit produces a one-cycle load pulse that hands all seven shadow bytes to the counter at once. The control byte also holds a signed calibration value. Several byte positions hold user flags that drive the block's outputs.

Top module: `rtc_shadow_port`

## Requirements
- R1: Addresses from 2^ADDR_W-8 upward select the clock window, with byte order control, seconds, minutes, hours, century/day, date, month, year. Any other address raises `mem_sel` while `cs` is high and, on a read, returns `mem_rdata`. `rdata` is 0 when no read (`cs & oe & ~we`) is active.
- R2: The control byte has the write-halt bit at bit 7, the read-halt bit at bit 6, the calibration sign at bit 5 and the calibration magnitude at bits 4:0. It is always writable, it reads back as written, and `cal_sign` and `cal_mag` follow it.
- R3: A `tick` cycle with neither halt bit set loads every counter-owned field of all seven time bytes from `cnt_time` in the same clock edge. Byte k comes from bits 8k+7:8k, with k=0 for seconds and k=6 for years. The counter-owned masks are seconds 7Fh, minutes 7Fh, hours 3Fh, century/day 17h, date 3Fh, month 1Fh, year FFh.
- R4: While the read-halt bit is 1, ticks leave every time byte unchanged. After the bit is cleared, the next tick updates them again.
- R5: A tick that arrives on the same edge as a control write that sets a halt bit is still applied in full. The halt takes effect from the following edge.
- R6: While the write-halt bit is 1, ticks are ignored. A control write that takes bit 7 from 1 to 0 raises `load_pulse` for exactly one cycle after that edge. `load_time` then carries the seven stored time bytes in the R3 order, with the battery-low position read as 0.
- R7: Counter-owned fields accept bus writes only while the write-halt bit is 1. Otherwise those writes are ignored.
- R8: The user bits are oscillator stop (seconds bit 7), frequency test (century/day bit 6), century enable (century/day bit 5) and battery-low enable (date bit 7). They are writable at any time and survive ticks. They drive `osc_stop`, `freq_test`, `century_en` and `batt_low_en`.
- R9: The century bit (century/day bit 4) can be written only while the write-halt bit is 1. Century enable can be written without it.
- R10: Fields defined as zero always read 0 whatever is written. These are minutes bit 7, hours bits 7:6, century/day bits 7 and 3, and month bits 7:5.
- R11: Date bit 6 is the battery-low flag. It reads as the `batt_low_in` input, and bus writes to it are ignored.
- R12: After reset the control byte is 00h, seconds reads 80h (oscillator stopped), the other time bytes read 00h, and `load_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable |
| oe | input | 1 | Output enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is active |
| mem_sel | output | 1 | Select for ordinary memory |
| mem_rdata | input | 8 | Read data from ordinary memory |
| tick | input | 1 | One-cycle pulse each second from the counter |
| cnt_time | input | 56 | Current counter time, seven bytes |
| load_pulse | output | 1 | One-cycle commit request to the counter |
| load_time | output | 56 | Time bytes to commit |
| cal_sign | output | 1 | Calibration sign |
| cal_mag | output | 5 | Calibration magnitude |
| osc_stop | output | 1 | Oscillator stop flag |
| freq_test | output | 1 | Frequency test enable |
| century_en | output | 1 | Century toggle enable |
| batt_low_en | output | 1 | Battery-low check enable |
| batt_low_in | input | 1 | Battery-low flag from monitor |

## Verification
The bench reads every address in the space. A decoder whose boundary is off by one would either send a clock byte to memory or claim a memory byte for the window. It drives a tick on the same edge as a halting control write. A design that samples the halt bit after the write would lose that update, which breaks R5. It writes all-ones and all-zeros patterns with the write-halt bit both set and clear. This exposes a design that stores zero-defined fields, lets the century bit through unlocked, or lets a tick wipe the user flags. It checks that the commit pulse lasts one cycle and that `load_time` matches the bench's own model of the shadow bytes.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int unsigned REG_COUNT  = 8;
    localparam int unsigned TIME_BYTES = REG_COUNT - 1;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned TIME_W     = TIME_BYTES * BYTE_W;
    localparam int unsigned IDX_W      = $clog2(REG_COUNT);

    // control byte positions
    localparam int unsigned CTL_WHALT = 7;
    localparam int unsigned CTL_RHALT = 6;
    localparam int unsigned CTL_SIGN  = 5;

    // time byte indices (address offset minus one)
    localparam int unsigned TB_SEC  = 0;
    localparam int unsigned TB_DAY  = 3;
    localparam int unsigned TB_DATE = 4;

    localparam int unsigned BL_BIT  = 6;

    typedef struct packed {
        logic       whalt;
        logic       rhalt;
        logic       sign;
        logic [4:0] mag;
    } ctl_t;

    // bits owned by the calendar counter
    function automatic logic [7:0] ctr_mask(input int unsigned t);
        case (t)
            0:       return 8'h7F;
            1:       return 8'h7F;
            2:       return 8'h3F;
            3:       return 8'h17;
            4:       return 8'h3F;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // flags owned by software, writable at any time
    function automatic logic [7:0] user_mask(input int unsigned t);
        case (t)
            0:       return 8'h80;
            3:       return 8'h60;
            4:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(input int unsigned t);
        return (t == 0) ? 8'h80 : 8'h00;
    endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
    import rtc_shadow_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'((1 << ADDR_W) - REG_COUNT);

    assign hit = (addr >= WIN_BASE);
    assign idx = addr[IDX_W-1:0];
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_shadow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic       load_pulse
);
    ctl_t ctl_q;
    logic load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            load_q <= 1'b0;
        end else if (wr) begin
            ctl_q  <= ctl_t'(wdata);
            load_q <= ctl_q.whalt & ~wdata[CTL_WHALT];
        end else begin
            load_q <= 1'b0;
        end
    end

    assign ctl        = ctl_q;
    assign load_pulse = load_q;

    p_commit_edge_r6: assert property (@(posedge clk) disable iff (rst)
        load_q |-> ($past(ctl_q.whalt) && !ctl_q.whalt));

    p_commit_single_r6: assert property (@(posedge clk) disable iff (rst)
        load_q |=> !load_q);
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
    import rtc_shadow_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [TIME_W-1:0]     cnt_time,
    input  logic                  halt,
    input  logic                  unlock,
    input  logic [TIME_BYTES-1:0] wr_hit,
    input  logic [7:0]            wdata,
    output logic [TIME_W-1:0]     time_bus
);
    logic [TIME_BYTES-1:0][7:0] time_q;

    for (genvar t = 0; t < TIME_BYTES; t++) begin : g_byte
        localparam logic [7:0] CM = ctr_mask(t);
        localparam logic [7:0] UM = user_mask(t);
        logic [7:0] nxt;
        logic [7:0] wmask;

        always_comb begin
            nxt = time_q[t];
            if (tick && !halt) begin
                nxt = (cnt_time[BYTE_W*t +: BYTE_W] & CM) | (time_q[t] & UM);
            end
            wmask = UM | (unlock ? CM : 8'h00);
            if (wr_hit[t]) begin
                nxt = (nxt & ~wmask) | (wdata & wmask);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) time_q[t] <= reset_value(t);
            else     time_q[t] <= nxt;
        end

        assign time_bus[BYTE_W*t +: BYTE_W] = time_q[t];

        p_tick_load_r3: assert property (@(posedge clk) disable iff (rst)
            (tick && !halt) |=> ((time_q[t] & CM) == ($past(cnt_time[BYTE_W*t +: BYTE_W]) & CM)));

        p_zero_fields_r10: assert property (@(posedge clk) disable iff (rst)
            (time_q[t] & ~(CM | UM)) == 8'h00);
    end

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (halt && (wr_hit == '0)) |=> $stable(time_q));
endmodule

// File: rtl/rtc_shadow_port.sv
module rtc_shadow_port
    import rtc_shadow_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              mem_sel,
    input  logic [7:0]        mem_rdata,
    input  logic              tick,
    input  logic [55:0]       cnt_time,
    output logic              load_pulse,
    output logic [55:0]       load_time,
    output logic              cal_sign,
    output logic [4:0]        cal_mag,
    output logic              osc_stop,
    output logic              freq_test,
    output logic              century_en,
    output logic              batt_low_en,
    input  logic              batt_low_in
);
    logic                  hit;
    logic [IDX_W-1:0]      idx;
    logic                  wr_en;
    logic                  rd_en;
    ctl_t                  ctl;
    logic [TIME_W-1:0]     time_bus;
    logic [TIME_BYTES-1:0] wr_hit;
    logic [7:0]            view [REG_COUNT];

    rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hit  (hit),
        .idx  (idx)
    );

    assign wr_en = cs & we;
    assign rd_en = cs & oe & ~we;

    rtc_ctrl_reg u_ctl (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_en & hit & (idx == '0)),
        .wdata      (wdata),
        .ctl        (ctl),
        .load_pulse (load_pulse)
    );

    for (genvar t = 0; t < TIME_BYTES; t++) begin : g_wr
        assign wr_hit[t] = wr_en & hit & (idx == IDX_W'(t + 1));
    end

    rtc_shadow_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt_time (cnt_time),
        .halt     (ctl.whalt | ctl.rhalt),
        .unlock   (ctl.whalt),
        .wr_hit   (wr_hit),
        .wdata    (wdata),
        .time_bus (time_bus)
    );

    assign view[0] = ctl;
    for (genvar t = 0; t < TIME_BYTES; t++) begin : g_view
        if (t == TB_DATE) begin : g_bl
            assign view[t+1] = time_bus[BYTE_W*t +: BYTE_W] | (8'(batt_low_in) << BL_BIT);
        end else begin : g_plain
            assign view[t+1] = time_bus[BYTE_W*t +: BYTE_W];
        end
    end

    assign rdata   = !rd_en ? 8'h00 : (hit ? view[idx] : mem_rdata);
    assign mem_sel = cs & ~hit;

    assign load_time   = time_bus;
    assign cal_sign    = ctl.sign;
    assign cal_mag     = ctl.mag;
    assign osc_stop    = time_bus[BYTE_W*TB_SEC  + 7];
    assign freq_test   = time_bus[BYTE_W*TB_DAY  + 6];
    assign century_en  = time_bus[BYTE_W*TB_DAY  + 5];
    assign batt_low_en = time_bus[BYTE_W*TB_DATE + 7];

    p_bl_follows_input_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit && idx == IDX_W'(TB_DATE + 1)) |-> (rdata[BL_BIT] == batt_low_in));

    p_load_after_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(load_pulse) |-> $past(wr_en && hit && idx == '0));
endmodule

// File: tb/rtc_shadow_port_bench.sv
module rtc_shadow_port_bench;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 0, we = 0, oe = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          mem_sel;
    logic [7:0]    mem_rdata;
    logic          tick = 0;
    logic [55:0]   cnt_time = '0;
    logic          load_pulse;
    logic [55:0]   load_time;
    logic          cal_sign;
    logic [4:0]    cal_mag;
    logic          osc_stop, freq_test, century_en, batt_low_en;
    logic          batt_low_in = 0;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_t [7];
    logic [7:0] exp_ctl;

    always #2 clk = ~clk;

    assign mem_rdata = addr[7:0] ^ 8'h5A;

    rtc_shadow_port #(.ADDR_W(AW)) u_rtc_shadow_port (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .oe(oe), .addr(addr),
        .wdata(wdata), .rdata(rdata), .mem_sel(mem_sel), .mem_rdata(mem_rdata),
        .tick(tick), .cnt_time(cnt_time), .load_pulse(load_pulse),
        .load_time(load_time), .cal_sign(cal_sign), .cal_mag(cal_mag),
        .osc_stop(osc_stop), .freq_test(freq_test), .century_en(century_en),
        .batt_low_en(batt_low_en), .batt_low_in(batt_low_in)
    );

    function automatic logic [7:0] cmask(int t);
        logic [7:0] m [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h17, 8'h3F, 8'h1F, 8'hFF};
        return m[t];
    endfunction

    function automatic logic [7:0] umask(int t);
        logic [7:0] m [7] = '{8'h80, 8'h00, 8'h00, 8'h60, 8'h80, 8'h00, 8'h00};
        return m[t];
    endfunction

    function automatic logic [7:0] exp_read(int i);
        if (i == 0) return exp_ctl;
        if (i == 5) return exp_t[4] | {1'b0, batt_low_in, 6'b0};
        return exp_t[i-1];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // one bus cycle: optional write and optional tick on the same edge
    task automatic step(bit do_wr, int i, logic [7:0] d, bit do_tick, logic [55:0] cnt);
        @(negedge clk);
        cs = do_wr; we = do_wr; oe = 0;
        addr = AW'((1 << AW) - 8 + i); wdata = d;
        tick = do_tick; cnt_time = cnt;
        @(negedge clk);
        cs = 0; we = 0; tick = 0;
        if (do_tick && !(exp_ctl[7] | exp_ctl[6]))
            for (int t = 0; t < 7; t++)
                exp_t[t] = (cnt[8*t +: 8] & cmask(t)) | (exp_t[t] & umask(t));
        if (do_wr) begin
            if (i == 0) exp_ctl = d;
            else begin
                logic [7:0] m;
                m = umask(i-1) | (exp_ctl[7] ? cmask(i-1) : 8'h00);
                exp_t[i-1] = (exp_t[i-1] & ~m) | (d & m);
            end
        end
    endtask

    task automatic rd_check(string tag, int i);
        cs = 1; oe = 1; we = 0; addr = AW'((1 << AW) - 8 + i);
        #1;
        check(tag, 64'(rdata), 64'(exp_read(i)));
        cs = 0; oe = 0;
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 8; i++) rd_check(tag, i);
    endtask

    function automatic logic [55:0] exp_bus();
        logic [55:0] v;
        for (int t = 0; t < 7; t++) v[8*t +: 8] = exp_t[t];
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_ctl = 8'h00;
        for (int t = 0; t < 7; t++) exp_t[t] = (t == 0) ? 8'h80 : 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R12 reset state
        check_all("R12 reset read");
        check("R12 load_pulse", 64'(load_pulse), 0);
        check("R12 osc_stop", 64'(osc_stop), 1);

        // R1 exhaustive address sweep
        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            cs = 1; oe = 1; we = 0; addr = AW'(a);
            #1;
            if (a >= (1 << AW) - 8) begin
                check("R1 window read", 64'(rdata), 64'(exp_read(a - ((1 << AW) - 8))));
                check("R1 window no mem_sel", 64'(mem_sel), 0);
            end else begin
                check("R1 mem read", 64'(rdata), 64'(8'(a) ^ 8'h5A));
                check("R1 mem_sel", 64'(mem_sel), 1);
            end
            cs = 0; oe = 0;
            #1;
            check("R1 idle rdata", 64'(rdata), 0);
        end

        // R2 calibration sweep, halt bits clear
        for (int v = 0; v < 64; v++) begin
            step(1, 0, 8'(v), 0, '0);
            check("R2 cal_sign", 64'(cal_sign), 64'((v >> 5) & 1));
            check("R2 cal_mag", 64'(cal_mag), 64'(v & 31));
            rd_check("R2 ctrl readback", 0);
        end
        step(1, 0, 8'h00, 0, '0);

        // R3 ticks with several patterns, user bits kept (stop still set)
        step(0, 0, 0, 1, {7{8'hFF}});
        check_all("R3 tick ones");
        check("R8 stop kept over tick", 64'(osc_stop), 1);
        step(0, 0, 0, 1, 56'h0);
        check_all("R3 tick zeros");
        step(0, 0, 0, 1, 56'h12_34_56_78_9A_BC_DE);
        check_all("R3 tick mixed");

        // R7 unlocked writes ignored, R8 user bits writable
        step(1, 1, 8'h00, 0, '0);
        check_all("R7 sec write locked");
        check("R8 osc_stop cleared", 64'(osc_stop), 0);
        step(1, 4, 8'hFF, 0, '0);
        check_all("R9 ceb without write bit");
        check("R8 freq_test", 64'(freq_test), 1);
        check("R8 century_en", 64'(century_en), 1);
        step(1, 5, 8'hFF, 0, '0);
        check("R8 batt_low_en", 64'(batt_low_en), 1);
        check_all("R11 date write");

        // R4 read halt
        step(1, 0, 8'h40, 0, '0);
        step(0, 0, 0, 1, 56'h11_22_33_44_55_66_77);
        check_all("R4 halted tick");
        step(1, 0, 8'h00, 0, '0);
        check("R4 no load on read clear", 64'(load_pulse), 0);
        step(0, 0, 0, 1, 56'h11_22_33_44_55_66_77);
        check_all("R4 resumed tick");

        // R5 tick on the same edge as the halting write
        step(1, 0, 8'h40, 1, 56'h01_02_03_04_05_06_07);
        check_all("R5 tick with halt write");
        step(0, 0, 0, 1, {7{8'hFF}});
        check_all("R5 halt after edge");
        step(1, 0, 8'h00, 0, '0);

        // R6 write halt, R9 century bit, R10 zero fields
        step(1, 0, 8'h80, 0, '0);
        step(0, 0, 0, 1, 56'h0);
        check_all("R6 write halt tick");
        for (int i = 1; i < 8; i++) step(1, i, 8'hFF, 0, '0);
        check_all("R10 ones written");
        step(1, 0, 8'h00, 0, '0);
        check("R6 load_pulse", 64'(load_pulse), 1);
        check("R6 load_time", 64'(load_time), 64'(exp_bus()));
        @(negedge clk);
        check("R6 pulse one cycle", 64'(load_pulse), 0);
        step(1, 4, 8'h00, 0, '0);
        step(1, 4, 8'h20, 0, '0);
        check_all("R9 cb locked");
        step(1, 0, 8'h80, 0, '0);
        step(1, 4, 8'h10, 0, '0);
        check_all("R9 cb unlocked");
        for (int i = 1; i < 8; i++) step(1, i, 8'h00, 0, '0);
        check_all("R10 zeros written");
        step(1, 0, 8'h00, 0, '0);
        check("R6 load_time zeros", 64'(load_time), 64'(exp_bus()));

        // R11 battery-low flag follows input
        batt_low_in = 1;
        rd_check("R11 bl high", 5);
        step(1, 5, 8'h00, 0, '0);
        rd_check("R11 bl write ignored", 5);
        batt_low_in = 0;
        rd_check("R11 bl low", 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule